// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block sits beside a four-stage-plus-write-back in-order pipeline and turns per-stage fault reports and an external interrupt line into one precise trap. Each of the fetch, decode, execute and memory stages presents a valid bit, a cause code and the PC of the instruction it holds. In the same cycle the block picks the fault that belongs to the oldest instruction. It raises a flush for that stage and every younger stage, and it steers fetch to a handler. Stages older than the faulting one are left alone and complete. Write-back never faults and is never flushed.

A flush bit also suppresses the register-file write and the data-memory write of the instruction in that stage. A taken trap captures the instruction's PC and cause into holding registers on the next clock edge. The handler entry is either a single base address or, in vectored mode, the base offset by the cause times 32. An external interrupt has the lowest priority. It is charged to the instruction in the memory stage, which is flushed and will re-execute. A return request sends fetch back to the saved PC. Interrupts stay masked from trap entry until that return.

Top module: `precise_trap_unit`

## Requirements
- R1: Stage indices are fetch=0, decode=1, execute=2, memory=3, and a higher index is an older instruction. When several stages report a fault in one cycle, the trap taken is the one from the highest index.
- R2: On a fault taken from stage k, `flush[k]` and every `flush` bit below k are 1 in that same cycle, and the bits above k are 0. A flushed stage performs no register or memory write.
- R3: On the clock edge after a trap is taken, `epc` holds the PC of the trapped instruction.
- R4: On the clock edge after a trap is taken, `cause` holds its 5-bit code. The codes are: 0 interrupt, 4 misaligned address, 6 fetch fault, 7 data fault, 10 illegal opcode, 12 overflow, 13 protection violation.
- R5: With `vec_mode`=0, a trap redirects fetch to the base address (default 0x8000_0000), with `redirect_vld`=1 in the same cycle.
- R6: With `vec_mode`=1, a trap redirects to base + cause*0x20.
- R7: An interrupt request that arrives while unmasked, with no fault and no return present, flushes all four stages. It records cause 0 and takes the memory-stage PC as `epc`.
- R8: When a fault and an unmasked interrupt occur in the same cycle, the fault is taken.
- R9: `irq_masked` becomes 1 on the edge after any trap. While it is 1, an interrupt request causes no redirect and no flush.
- R10: A return request redirects fetch to `epc` and flushes all four stages in the same cycle. It clears `irq_masked` on the next edge.
- R11: When a return and a fault occur in the same cycle, the return is taken. `epc` and `cause` keep their values.
- R12: After reset, `epc`, `cause` and `irq_masked` are 0.
- R13: With no fault, no taken interrupt and no return, `redirect_vld` and every `flush` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_mode | input | 1 | 1 selects a vectored handler entry, 0 selects the fixed entry |
| flt_vld | input | NSTG | Per-stage fault valid, index 0 = fetch |
| flt_code | input | NSTG*5 | Per-stage cause code, 5 bits per stage |
| stage_pc | input | NSTG*32 | PC of the instruction held in each stage |
| irq_req | input | 1 | External interrupt request |
| eret | input | 1 | Return-from-trap request |
| redirect_vld | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | Handler entry, or the saved PC on return |
| flush | output | NSTG | Per-stage squash and write suppression |
| epc | output | 32 | Saved PC of the trapped instruction |
| cause | output | 5 | Saved cause code |
| irq_masked | output | 1 | Interrupts blocked until return |

## Verification
Trap entry and return can occur in the same cycle. So can a fault and an interrupt. The bench provokes both cases by raising the two inputs together, after it has loaded `epc` and `cause` with known values. For entry against return, it checks that the redirect targets the old `epc`, that all stages flush, and that `epc`, `cause` and the mask after the edge show a return and not a new trap. For fault against interrupt, it checks that the flush pattern and the recorded cause belong to the fault.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PC_W = 32;
  localparam int CW   = 5;

  localparam logic [CW-1:0] CAUSE_IRQ     = 5'd0;
  localparam logic [CW-1:0] CAUSE_ALIGN   = 5'd4;
  localparam logic [CW-1:0] CAUSE_IFAULT  = 5'd6;
  localparam logic [CW-1:0] CAUSE_DFAULT  = 5'd7;
  localparam logic [CW-1:0] CAUSE_ILLEGAL = 5'd10;
  localparam logic [CW-1:0] CAUSE_OVF     = 5'd12;
  localparam logic [CW-1:0] CAUSE_PROT    = 5'd13;

  // Handler entry: base, or base plus the cause scaled by 2**shift
  function automatic logic [PC_W-1:0] handler_target(
      input logic [PC_W-1:0] base, input logic vec,
      input logic [CW-1:0] code, input int shift);
    logic [PC_W-1:0] off;
    off = PC_W'(code) << shift;
    return vec ? base + off : base;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int NSTG = 4,
  localparam int IW = $clog2(NSTG)
) (
  input  logic [NSTG-1:0]      flt_vld,
  input  logic [NSTG*CW-1:0]   flt_code,
  input  logic [NSTG*PC_W-1:0] stage_pc,
  output logic                 hit,
  output logic [IW-1:0]        sel_idx,
  output logic [CW-1:0]        sel_code,
  output logic [PC_W-1:0]      sel_pc
);
  // Ascending scan: a later (older) stage overrides a younger one
  always_comb begin
    hit      = 1'b0;
    sel_idx  = '0;
    sel_code = '0;
    sel_pc   = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (flt_vld[i]) begin
        hit      = 1'b1;
        sel_idx  = IW'(i);
        sel_code = flt_code[i*CW +: CW];
        sel_pc   = stage_pc[i*PC_W +: PC_W];
      end
    end
  end
endmodule

// File: rtl/trap_flush.sv
module trap_flush #(
  parameter int NSTG = 4,
  localparam int IW = $clog2(NSTG)
) (
  input  logic            take_fault,
  input  logic [IW-1:0]   fault_idx,
  input  logic            take_all,
  output logic [NSTG-1:0] flush
);
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    assign flush[g] = take_all | (take_fault && (IW'(g) <= fault_idx));
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic [PC_W-1:0] enter_pc,
  input  logic [CW-1:0]   enter_code,
  input  logic            leave,
  output logic [PC_W-1:0] epc_q,
  output logic [CW-1:0]   cause_q,
  output logic            masked_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q    <= '0;
      cause_q  <= '0;
      masked_q <= 1'b0;
    end else if (enter) begin
      epc_q    <= enter_pc;
      cause_q  <= enter_code;
      masked_q <= 1'b1;
    end else if (leave) begin
      masked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
  import trap_pkg::*;
#(
  parameter int              NSTG         = 4,
  parameter logic [PC_W-1:0] HANDLER_BASE = 32'h8000_0000,
  parameter int              VEC_SHIFT    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vec_mode,
  input  logic [NSTG-1:0]      flt_vld,
  input  logic [NSTG*CW-1:0]   flt_code,
  input  logic [NSTG*PC_W-1:0] stage_pc,
  input  logic                 irq_req,
  input  logic                 eret,
  output logic                 redirect_vld,
  output logic [PC_W-1:0]      redirect_pc,
  output logic [NSTG-1:0]      flush,
  output logic [PC_W-1:0]      epc,
  output logic [CW-1:0]        cause,
  output logic                 irq_masked
);
  localparam int IW = $clog2(NSTG);

  // Named internal events, observed by the bound checker
  logic            hit;
  logic [IW-1:0]   sel_idx;
  logic [CW-1:0]   sel_code;
  logic [PC_W-1:0] sel_pc;
  logic            exc_take, irq_take, enter;
  logic [CW-1:0]   enter_code;
  logic [PC_W-1:0] enter_pc;

  trap_arbiter #(.NSTG(NSTG)) u_arb (
    .flt_vld(flt_vld), .flt_code(flt_code), .stage_pc(stage_pc),
    .hit(hit), .sel_idx(sel_idx), .sel_code(sel_code), .sel_pc(sel_pc));

  // Priority: return, then oldest fault, then unmasked interrupt
  assign exc_take   = hit && !eret;
  assign irq_take   = irq_req && !irq_masked && !hit && !eret;
  assign enter      = exc_take || irq_take;
  assign enter_code = exc_take ? sel_code : CAUSE_IRQ;
  assign enter_pc   = exc_take ? sel_pc : stage_pc[(NSTG-1)*PC_W +: PC_W];

  trap_flush #(.NSTG(NSTG)) u_flush (
    .take_fault(exc_take), .fault_idx(sel_idx),
    .take_all(eret || irq_take), .flush(flush));

  trap_state u_state (
    .clk(clk), .rst_n(rst_n), .enter(enter), .enter_pc(enter_pc),
    .enter_code(enter_code), .leave(eret),
    .epc_q(epc), .cause_q(cause), .masked_q(irq_masked));

  assign redirect_vld = enter || eret;
  assign redirect_pc  = eret ? epc
                      : handler_target(HANDLER_BASE, vec_mode, enter_code, VEC_SHIFT);
endmodule

// File: rtl/precise_trap_unit_chk.sv
module precise_trap_unit_chk
  import trap_pkg::*;
#(
  parameter int              NSTG         = 4,
  parameter logic [PC_W-1:0] HANDLER_BASE = 32'h8000_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 vec_mode,
  input logic [NSTG-1:0]      flt_vld,
  input logic [NSTG*CW-1:0]   flt_code,
  input logic                 irq_req,
  input logic                 eret,
  input logic                 redirect_vld,
  input logic [PC_W-1:0]      redirect_pc,
  input logic [NSTG-1:0]      flush,
  input logic [PC_W-1:0]      epc,
  input logic [CW-1:0]        cause,
  input logic                 irq_masked,
  input logic                 exc_take
);
  // R1: an oldest-stage fault sets the recorded cause
  assert_oldest_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld[NSTG-1] && !eret) |=> cause == $past(flt_code[(NSTG-1)*CW +: CW]));

  // R2: a faulting stage is always flushed
  for (genvar g = 0; g < NSTG; g++) begin : g_fl
    assert_fault_flushed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_vld[g] && !eret) |-> flush[g]);
  end

  // R6: a vectored entry keeps the base alignment
  assert_vector_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && exc_take) |-> redirect_pc[4:0] == HANDLER_BASE[4:0]);

  // R9: a masked interrupt alone does nothing
  assert_masked_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_masked && irq_req && flt_vld == '0 && !eret) |-> !redirect_vld);

  // R9: entry sets the mask
  assert_entry_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> irq_masked);

  // R10: return targets the saved PC and unmasks
  assert_return_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eret |-> (redirect_pc == epc && flush == '1));
  assert_return_unmask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eret |=> !irq_masked);

  // R11: return in the same cycle as a fault leaves the saved state intact
  assert_return_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && flt_vld != '0) |=> $stable(epc) && $stable(cause));

  // R13: quiet inputs give no redirect and no flush
  assert_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld == '0 && !irq_req && !eret) |-> (!redirect_vld && flush == '0));
endmodule

bind precise_trap_unit precise_trap_unit_chk #(.NSTG(NSTG), .HANDLER_BASE(HANDLER_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .flt_vld(flt_vld),
  .flt_code(flt_code), .irq_req(irq_req), .eret(eret),
  .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .flush(flush),
  .epc(epc), .cause(cause), .irq_masked(irq_masked), .exc_take(exc_take));

// File: tb/tb_precise_trap_unit.sv
module tb_precise_trap_unit;
  localparam int CLK_P = 10;
  localparam int NV    = 9;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [127:0] PCS = {32'h0000_00F4, 32'h0000_00F8, 32'h0000_00FC, 32'h0000_0100};
  localparam logic [19:0] STD = {5'd7, 5'd12, 5'd10, 5'd6};

  // {vec, irq, vld[3:0], codes[19:0], exp_flush[3:0], exp_pc[31:0], exp_cause[4:0], exp_epc[31:0]}
  localparam logic [98:0] VT [NV] = '{
    {1'b0, 1'b0, 4'b0001, STD, 4'b0001, 32'h8000_0000, 5'd6,  32'h0000_0100},
    {1'b1, 1'b0, 4'b0010, STD, 4'b0011, 32'h8000_0140, 5'd10, 32'h0000_00FC},
    {1'b1, 1'b0, 4'b0100, STD, 4'b0111, 32'h8000_0180, 5'd12, 32'h0000_00F8},
    {1'b1, 1'b0, 4'b1000, STD, 4'b1111, 32'h8000_00E0, 5'd7,  32'h0000_00F4},
    {1'b1, 1'b0, 4'b0111, STD, 4'b0111, 32'h8000_0180, 5'd12, 32'h0000_00F8},
    {1'b0, 1'b0, 4'b1010, {5'd13, 5'd12, 5'd10, 5'd6}, 4'b1111, 32'h8000_0000, 5'd13, 32'h0000_00F4},
    {1'b1, 1'b1, 4'b0000, STD, 4'b1111, 32'h8000_0000, 5'd0,  32'h0000_00F4},
    {1'b1, 1'b1, 4'b0010, STD, 4'b0011, 32'h8000_0140, 5'd10, 32'h0000_00FC},
    {1'b1, 1'b0, 4'b0001, {5'd7, 5'd12, 5'd10, 5'd4}, 4'b0001, 32'h8000_0080, 5'd4, 32'h0000_0100}
  };

  logic clk = 1'b0, rst_n = 1'b0, vec_mode = 1'b0, irq_req = 1'b0, eret = 1'b0;
  logic [3:0] flt_vld = '0;
  logic [19:0] flt_code = STD;
  logic [127:0] stage_pc = PCS;
  logic redirect_vld, irq_masked;
  logic [31:0] redirect_pc, epc;
  logic [3:0] flush;
  logic [4:0] cause;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  precise_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .flt_vld(flt_vld),
    .flt_code(flt_code), .stage_pc(stage_pc), .irq_req(irq_req), .eret(eret),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .flush(flush),
    .epc(epc), .cause(cause), .irq_masked(irq_masked));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    flt_vld = '0; irq_req = 1'b0; eret = 1'b0; flt_code = STD;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // Return to the saved PC and leave the mask clear
  task automatic do_return(input logic [31:0] exp_epc);
    idle(); eret = 1'b1; #1;
    check("R10 return pc", redirect_pc, exp_epc);
    check("R10 return flush", 32'(flush), 32'hF);
    tick(); idle();
    check("R10 mask cleared", 32'(irq_masked), 0);
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R12: reset state
    check("R12 epc", epc, 0);
    check("R12 cause", 32'(cause), 0);
    check("R12 mask", 32'(irq_masked), 0);
    rst_n = 1'b1; tick();
    // R13: idle gives nothing
    #1;
    check("R13 no redirect", 32'(redirect_vld), 0);
    check("R13 no flush", 32'(flush), 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [98:0] e;
      e = VT[v];
      vec_mode = e[98]; irq_req = e[97]; flt_vld = e[96:93]; flt_code = e[92:73];
      #1;
      check($sformatf("R1 R2 R8 flush v%0d", v), 32'(flush), 32'(e[72:69]));
      check($sformatf("R5 R6 R7 target v%0d", v), redirect_pc, e[68:37]);
      check($sformatf("R5 redirect v%0d", v), 32'(redirect_vld), 1);
      tick(); idle();
      check($sformatf("R4 cause v%0d", v), 32'(cause), 32'(e[36:32]));
      check($sformatf("R3 epc v%0d", v), epc, e[31:0]);
      check($sformatf("R9 masked v%0d", v), 32'(irq_masked), 1);
      do_return(e[31:0]);
    end

    // R9: masked interrupt ignored, nested fault still taken
    vec_mode = 1'b0; flt_vld = 4'b0100; #1; tick(); idle();
    irq_req = 1'b1; #1;
    check("R9 masked irq no redirect", 32'(redirect_vld), 0);
    check("R9 masked irq no flush", 32'(flush), 0);
    tick(); idle();
    check("R9 masked irq epc kept", epc, 32'h0000_00F8);
    check("R9 masked irq cause kept", 32'(cause), 12);

    // R11: return and fault together; return wins
    eret = 1'b1; flt_vld = 4'b1000; irq_req = 1'b1; #1;
    check("R11 return pc wins", redirect_pc, 32'h0000_00F8);
    check("R11 flush all", 32'(flush), 32'hF);
    tick(); idle();
    check("R11 epc unchanged", epc, 32'h0000_00F8);
    check("R11 cause unchanged", 32'(cause), 12);
    check("R11 mask cleared", 32'(irq_masked), 0);

    // R7: after return, interrupt is taken again
    irq_req = 1'b1; #1;
    check("R7 irq after return", 32'(redirect_vld), 1);
    tick(); idle();
    check("R7 irq cause", 32'(cause), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule